// File: doc/BRIEF.md
# Triggered Capture Unit with Sample Qualification

This block is one capture channel of an on-chip logic analyser. A wide probe bus carries several equally sized probe groups, and a run-time field picks the group that is watched. Two independent comparators look at the selected word. The trigger comparator opens a capture window. The qualification comparator decides, cycle by cycle, whether the current sample is worth keeping. Kept samples are stamped with a window sequence number and a free-running timestamp. They go into a local FIFO, which empties into a downstream transport through a valid/ready stream.

All conditions are programmed through a simple write-only register port while the design runs. This covers the operator, the low and high thresholds, the compare mask, the group select, the window length, and the repeat and enable controls. In single mode the unit captures one window and then goes idle. In repeat mode it re-arms after each window has drained. This gives a series of short, interrupted captures spread over a long time span. When samples arrive faster than the stream can accept them, the excess is discarded and a sticky flag records the loss.

Top module: `trig_capture_unit`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `out_valid_o` is 0 and `ovf_o` is 0.
- R2: Register 0 bits [7:4] select the observed group g, taken from `probe_i[g*GROUP_W +: GROUP_W]`. Only that group reaches the comparators and the stored word.
- R3: Operator codes, applied to (data AND mask) against the low threshold, are: 0 equal, 1 not equal, 2 less than, 3 greater than. Codes 6 and 7 are always true. Trigger registers: op 1, low 2, high 3, mask 4. Qualification registers: op 5, low 6, high 7, mask 8.
- R4: Code 4 (in range) is true when low <= (data AND mask) <= high, with both bounds inclusive. Code 5 (out of range) is its exact complement.
- R5: A register 0 write with bit0 = 1 moves the unit from idle (0) to armed (1). A trigger hit while armed starts a window, and the sample in the trigger cycle is stored if it qualifies.
- R6: During a window, only samples that meet the qualification condition are stored. The window length counts qualified samples only.
- R7: After the number of qualified samples set in register 9, the unit enters draining (3). Once the buffer is empty it returns to idle in single mode, or to armed when register 0 bit1 (repeat) is set. Triggers seen while idle store nothing.
- R8: Each trigger starts a new window whose words carry a sequence number one higher than the previous window's.
- R9: A register 0 write with bit0 = 0 forces idle at once. From that cycle on, nothing is triggered or stored.
- R10: Output word layout is {seq[39:32], timestamp[31:16], data[15:0]}. The timestamp rises by one every clock.
- R11: A qualified sample that finds the buffer full with no pop in the same cycle is dropped, and `ovf_o` is set and stays set. Writing bit0 = 1 to register 10 clears it. If a set and a clear fall in the same cycle, the set wins.
- R12: Words leave in capture order. While `out_valid_o` is high and `out_ready_i` is low, the word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_i | input | NUM_GROUPS*GROUP_W | All probe groups, group g at bits g*GROUP_W upward |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration register index |
| cfg_wdata_i | input | GROUP_W | Configuration write data |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | SEQ_W+TS_W+GROUP_W | Sequence number, timestamp and sample |
| state_o | output | 2 | 0 idle, 1 armed, 2 capturing, 3 draining |
| ovf_o | output | 1 | Sticky sample-loss flag |

## Verification
The overflow flag can be set by a dropped sample in the same cycle that software writes the clear register. The bench provokes this by holding `out_ready_i` low through a window longer than the buffer, so that every cycle drops a sample. It then writes the clear register while the capture is still running. The flag must still read high after that edge. It must read low only after the unit has been disabled and the clear is written again.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_NE  = 3'd1,
    OP_LT  = 3'd2,
    OP_GT  = 3'd3,
    OP_IN  = 3'd4,
    OP_OUT = 3'd5,
    OP_ANY = 3'd6,
    OP_ALL = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DRAIN = 2'd3
  } cap_state_e;

  localparam int RA_CTRL   = 0;
  localparam int RA_T_OP   = 1;
  localparam int RA_T_LO   = 2;
  localparam int RA_T_HI   = 3;
  localparam int RA_T_MASK = 4;
  localparam int RA_Q_OP   = 5;
  localparam int RA_Q_LO   = 6;
  localparam int RA_Q_HI   = 7;
  localparam int RA_Q_MASK = 8;
  localparam int RA_WIN    = 9;
  localparam int RA_CLR    = 10;
endpackage

// File: rtl/cap_group_mux.sv
module cap_group_mux #(
  parameter int NUM_GROUPS = 16,
  parameter int GROUP_W    = 16,
  localparam int SEL_W     = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS*GROUP_W-1:0] probe_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [GROUP_W-1:0]            data_o
);
  logic [GROUP_W-1:0] grp [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_split
    assign grp[g] = probe_i[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    data_o = grp[0];
    for (int g = 1; g < NUM_GROUPS; g++) begin
      if (sel_i == SEL_W'(g)) data_o = grp[g];
    end
  end
endmodule

// File: rtl/cap_cond_cmp.sv
module cap_cond_cmp
  import cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  output logic         hit_o
);
  logic [W-1:0] m;
  logic         in_rng;

  assign m      = data_i & mask_i;
  assign in_rng = (m >= lo_i) && (m <= hi_i);

  always_comb begin
    unique case (cmp_op_e'(op_i))
      OP_EQ:   hit_o = (m == lo_i);
      OP_NE:   hit_o = (m != lo_i);
      OP_LT:   hit_o = (m <  lo_i);
      OP_GT:   hit_o = (m >  lo_i);
      OP_IN:   hit_o = in_rng;
      OP_OUT:  hit_o = !in_rng;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cap_sample_fifo.sv
module cap_sample_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
  import cap_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic             repeat_i,
  input  logic             trig_i,
  input  logic             qual_i,
  input  logic             buf_empty_i,
  input  logic [WIN_W-1:0] win_i,
  output cap_state_e       state_o,
  output logic             sample_o,
  output logic             start_o
);
  cap_state_e       st_q, st_d;
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   cnt_nx;
  logic             last;

  always_comb begin
    start_o  = (st_q == ST_ARMED) && trig_i && !stop_i;
    sample_o = qual_i && !stop_i && (start_o || st_q == ST_CAPT);
    cnt_nx   = (start_o ? '0 : {1'b0, cnt_q}) + (WIN_W+1)'(sample_o);
    // zero-length window behaves as length one
    last     = sample_o && (cnt_nx >= {1'b0, win_i});
    st_d     = st_q;
    if (stop_i) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (arm_i) st_d = ST_ARMED;
        ST_ARMED: if (start_o) st_d = last ? ST_DRAIN : ST_CAPT;
        ST_CAPT:  if (last) st_d = ST_DRAIN;
        ST_DRAIN: if (buf_empty_i) st_d = repeat_i ? ST_ARMED : ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o || st_q == ST_CAPT) cnt_q <= cnt_nx[WIN_W-1:0];
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/trig_capture_unit.sv
module trig_capture_unit
  import cap_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int GROUP_W    = 16,
  parameter int DEPTH      = 2048,
  parameter int TS_W       = 16,
  parameter int SEQ_W      = 8,
  parameter int ADDR_W     = 4,
  localparam int SEL_W     = $clog2(NUM_GROUPS),
  localparam int OUT_W     = SEQ_W + TS_W + GROUP_W,
  localparam int PROBE_W   = NUM_GROUPS * GROUP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [GROUP_W-1:0] cfg_wdata_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [OUT_W-1:0]   out_data_o,
  output logic [1:0]         state_o,
  output logic               ovf_o
);
  logic               en_q, rpt_q;
  logic [SEL_W-1:0]   gsel_q;
  logic [2:0]         t_op_q, q_op_q;
  logic [GROUP_W-1:0] t_lo_q, t_hi_q, t_mask_q;
  logic [GROUP_W-1:0] q_lo_q, q_hi_q, q_mask_q;
  logic [GROUP_W-1:0] win_q;
  logic [TS_W-1:0]    ts_q;
  logic [SEQ_W-1:0]   cur_seq_q, nxt_seq_q, word_seq;
  logic               ovf_q;

  logic               wr_ctrl, arm, stop, clr;
  logic [GROUP_W-1:0] sel_data;
  logic               trig_hit, qual_hit;
  logic               sample, start, full, empty, pop;
  cap_state_e         st;

  function automatic logic sel_reg(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign wr_ctrl = cfg_we_i && sel_reg(cfg_addr_i, RA_CTRL);
  assign arm     = wr_ctrl && cfg_wdata_i[0];
  assign stop    = wr_ctrl && !cfg_wdata_i[0];
  assign clr     = cfg_we_i && sel_reg(cfg_addr_i, RA_CLR) && cfg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      rpt_q    <= 1'b0;
      gsel_q   <= '0;
      t_op_q   <= OP_EQ;
      t_lo_q   <= '0;
      t_hi_q   <= '0;
      t_mask_q <= '1;
      q_op_q   <= OP_ANY;
      q_lo_q   <= '0;
      q_hi_q   <= '0;
      q_mask_q <= '1;
      win_q    <= GROUP_W'(1);
    end else if (cfg_we_i) begin
      if (sel_reg(cfg_addr_i, RA_CTRL)) begin
        en_q   <= cfg_wdata_i[0];
        rpt_q  <= cfg_wdata_i[1];
        gsel_q <= cfg_wdata_i[4 +: SEL_W];
      end
      if (sel_reg(cfg_addr_i, RA_T_OP))   t_op_q   <= cfg_wdata_i[2:0];
      if (sel_reg(cfg_addr_i, RA_T_LO))   t_lo_q   <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_T_HI))   t_hi_q   <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_T_MASK)) t_mask_q <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_Q_OP))   q_op_q   <= cfg_wdata_i[2:0];
      if (sel_reg(cfg_addr_i, RA_Q_LO))   q_lo_q   <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_Q_HI))   q_hi_q   <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_Q_MASK)) q_mask_q <= cfg_wdata_i;
      if (sel_reg(cfg_addr_i, RA_WIN))    win_q    <= cfg_wdata_i;
    end
  end

  cap_group_mux #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_mux (
    .probe_i(probe_i), .sel_i(gsel_q), .data_o(sel_data)
  );

  cap_cond_cmp #(.W(GROUP_W)) u_trig_cmp (
    .op_i(t_op_q), .lo_i(t_lo_q), .hi_i(t_hi_q), .mask_i(t_mask_q),
    .data_i(sel_data), .hit_o(trig_hit)
  );

  cap_cond_cmp #(.W(GROUP_W)) u_qual_cmp (
    .op_i(q_op_q), .lo_i(q_lo_q), .hi_i(q_hi_q), .mask_i(q_mask_q),
    .data_i(sel_data), .hit_o(qual_hit)
  );

  cap_seq_fsm #(.WIN_W(GROUP_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .stop_i(stop),
    .repeat_i(rpt_q), .trig_i(trig_hit && en_q), .qual_i(qual_hit),
    .buf_empty_i(empty), .win_i(win_q), .state_o(st),
    .sample_o(sample), .start_o(start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q      <= '0;
      cur_seq_q <= '0;
      nxt_seq_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (start) begin
        cur_seq_q <= nxt_seq_q;
        nxt_seq_q <= nxt_seq_q + 1'b1;
      end
      // a loss in the clearing cycle keeps the flag set
      if (sample && full && !pop) ovf_q <= 1'b1;
      else if (clr)               ovf_q <= 1'b0;
    end
  end

  assign word_seq = start ? nxt_seq_q : cur_seq_q;
  assign pop      = out_ready_i && !empty;

  cap_sample_fifo #(.W(OUT_W), .DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(sample),
    .wdata_i({word_seq, ts_q, sel_data}), .pop_i(pop),
    .rdata_o(out_data_o), .full_o(full), .empty_o(empty)
  );

  assign out_valid_o = !empty;
  assign state_o     = st;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/trig_capture_unit_chk.sv
module trig_capture_unit_chk #(
  parameter int ADDR_W = 4,
  parameter int OUT_W  = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic              cfg_bit0_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [OUT_W-1:0]  out_data_o,
  input logic [1:0]        state_o,
  input logic              ovf_o
);
  logic ctrl_wr, clr_wr;
  assign ctrl_wr = cfg_we_i && (cfg_addr_i == ADDR_W'(0));
  assign clr_wr  = cfg_we_i && (cfg_addr_i == ADDR_W'(10)) && cfg_bit0_i;

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_wr |=> ovf_o);

  // R12
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !cfg_bit0_i |=> state_o == 2'd0);

  // R5
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 && ctrl_wr && cfg_bit0_i |=> state_o == 2'd1);

  // R7
  drain_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 && !out_valid_o && !ctrl_wr |=> state_o == 2'd0 || state_o == 2'd1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 && !out_valid_o |=> !out_valid_o);
endmodule

bind trig_capture_unit trig_capture_unit_chk #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_bit0_i(cfg_wdata_i[0]), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .state_o(state_o), .ovf_o(ovf_o)
);

// File: tb/trig_capture_unit_tb_top.sv
`timescale 1ns/1ps
module trig_capture_unit_tb_top;
  localparam int NG = 16, GW = 16, DEP = 16, OW = 40;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NG*GW-1:0] probe = '0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_addr = '0;
  logic [GW-1:0]   cfg_wdata = '0;
  logic            out_valid, out_ready = 1'b0, ovf;
  logic [OW-1:0]   out_data;
  logic [1:0]      state;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  trig_capture_unit #(.NUM_GROUPS(NG), .GROUP_W(GW), .DEPTH(DEP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .probe_i(probe), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .state_o(state), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] mask;
    logic [15:0] data;
    logic        hit;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{3'd0, 16'h1234, 16'h0000, 16'hFFFF, 16'h1234, 1'b1},
    '{3'd0, 16'h1234, 16'h0000, 16'hFFFF, 16'h1235, 1'b0},
    '{3'd1, 16'h1234, 16'h0000, 16'hFFFF, 16'h1234, 1'b0},
    '{3'd1, 16'h1234, 16'h0000, 16'hFFFF, 16'h0000, 1'b1},
    '{3'd2, 16'h0064, 16'h0000, 16'hFFFF, 16'h0063, 1'b1},
    '{3'd2, 16'h0064, 16'h0000, 16'hFFFF, 16'h0064, 1'b0},
    '{3'd3, 16'h0064, 16'h0000, 16'hFFFF, 16'h0065, 1'b1},
    '{3'd3, 16'h0064, 16'h0000, 16'hFFFF, 16'h0064, 1'b0},
    '{3'd4, 16'h000A, 16'h0014, 16'hFFFF, 16'h000A, 1'b1},
    '{3'd4, 16'h000A, 16'h0014, 16'hFFFF, 16'h0014, 1'b1},
    '{3'd4, 16'h000A, 16'h0014, 16'hFFFF, 16'h0015, 1'b0},
    '{3'd5, 16'h000A, 16'h0014, 16'hFFFF, 16'h0009, 1'b1},
    '{3'd5, 16'h000A, 16'h0014, 16'hFFFF, 16'h000F, 1'b0},
    '{3'd0, 16'h0008, 16'h0000, 16'h0008, 16'hFFF8, 1'b1},
    '{3'd0, 16'h0008, 16'h0000, 16'h0008, 16'hFFF7, 1'b0},
    '{3'd7, 16'h0000, 16'h0000, 16'hFFFF, 16'h5A5A, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_grp(input int g, input logic [15:0] v);
    probe[g*GW +: GW] = v;
  endtask

  task automatic set_trig(input logic [2:0] op, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [15:0] mask);
    wr(1, 16'(op)); wr(2, lo); wr(3, hi); wr(4, mask);
  endtask

  task automatic set_qual(input logic [2:0] op, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [15:0] mask);
    wr(5, 16'(op)); wr(6, lo); wr(7, hi); wr(8, mask);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0]  s0;
    logic [15:0] d0, t0, head;
    #1;
    // R1 reset state
    chk("R1 state", 64'(state), 64'd0);
    chk("R1 valid", 64'(out_valid), 64'd0);
    chk("R1 ovf", 64'(ovf), 64'd0);
    step(); rst_ni = 1'b1; step();
    chk("R1 state after release", 64'(state), 64'd0);

    // comparator table (R3, R4, with R5/R7 window of one)
    out_ready = 1'b1;
    set_qual(3'd6, 16'h0, 16'h0, 16'hFFFF);
    wr(9, 16'd1);
    for (int i = 0; i < 16; i++) begin
      wr(0, 16'h0000);
      set_trig(VEC[i].op, VEC[i].lo, VEC[i].hi, VEC[i].mask);
      set_grp(0, VEC[i].data);
      wr(0, 16'h0001);
      step();
      chk((VEC[i].op == 3'd4 || VEC[i].op == 3'd5) ? "R4 range hit" : "R3 compare hit",
          64'(out_valid), 64'(VEC[i].hit));
      if (VEC[i].hit) begin
        chk("R5 trigger sample stored", 64'(out_data[15:0]), 64'(VEC[i].data));
        chk("R7 window of one drains", 64'(state), 64'd3);
      end
      step(); step();
    end
    wr(0, 16'h0000);
    step();

    // R2 group select
    for (int g = 0; g < NG; g++) set_grp(g, 16'(g * 16'h0111));
    set_trig(3'd0, 16'h0333, 16'h0, 16'hFFFF);
    wr(0, 16'h0031);
    step();
    chk("R2 group 3 hit", 64'(out_valid), 64'd1);
    chk("R2 group 3 data", 64'(out_data[15:0]), 64'h0333);
    step(); step();
    wr(0, 16'h0000);
    wr(0, 16'h0051);
    step();
    chk("R2 group 5 no hit", 64'(out_valid), 64'd0);
    wr(0, 16'h0000);
    probe = '0;

    // R6 qualification, R7 single-mode return
    out_ready = 1'b0;
    set_trig(3'd0, 16'h00AA, 16'h0, 16'hFFFF);
    set_qual(3'd0, 16'h0001, 16'h0, 16'h0001);
    wr(9, 16'd3);
    wr(0, 16'h0001);
    set_grp(0, 16'h00AA); step();
    set_grp(0, 16'h0011); step();
    set_grp(0, 16'h0020); step();
    set_grp(0, 16'h0013); step();
    chk("R6 window still open", 64'(state), 64'd2);
    set_grp(0, 16'h0015); step();
    chk("R7 enters draining", 64'(state), 64'd3);
    set_grp(0, 16'h0017); step();
    out_ready = 1'b1;
    chk("R6 word0", 64'(out_data[15:0]), 64'h0011);
    step();
    chk("R6 word1", 64'(out_data[15:0]), 64'h0013);
    step();
    chk("R6 word2", 64'(out_data[15:0]), 64'h0015);
    step();
    chk("R6 only qualified stored", 64'(out_valid), 64'd0);
    step();
    chk("R7 single returns idle", 64'(state), 64'd0);
    set_grp(0, 16'h00AB); step();
    set_grp(0, 16'h00AA); step(); step();
    chk("R7 idle ignores trigger", 64'(out_valid), 64'd0);

    // R8 repeat mode with sequence numbers
    out_ready = 1'b0;
    set_qual(3'd6, 16'h0, 16'h0, 16'hFFFF);
    wr(9, 16'd2);
    set_grp(0, 16'h0000);
    wr(0, 16'h0003);
    set_grp(0, 16'h00AA); step();
    set_grp(0, 16'h0001); step();
    set_grp(0, 16'h0000);
    out_ready = 1'b1;
    s0 = out_data[39:32];
    chk("R8 first window data", 64'(out_data[15:0]), 64'h00AA);
    step();
    chk("R8 same seq in window", 64'(out_data[39:32]), 64'(s0));
    step(); step();
    chk("R7 repeat re-arms", 64'(state), 64'd1);
    out_ready = 1'b0;
    set_grp(0, 16'h00AA); step();
    set_grp(0, 16'h0002); step();
    set_grp(0, 16'h0000);
    chk("R8 next seq", 64'(out_data[39:32]), 64'(s0 + 8'd1));
    out_ready = 1'b1;
    step();
    chk("R8 second window data", 64'(out_data[15:0]), 64'h0002);
    step();
    wr(0, 16'h0000);

    // R9 disable in armed cycle stores nothing
    out_ready = 1'b0;
    set_trig(3'd7, 16'h0, 16'h0, 16'hFFFF);
    wr(9, 16'd1);
    set_grp(0, 16'h0044);
    wr(0, 16'h0001);
    wr(0, 16'h0000);
    chk("R9 forced idle", 64'(state), 64'd0);
    step(); step();
    chk("R9 nothing stored", 64'(out_valid), 64'd0);

    // R11 overflow, R10 timestamps, R12 hold
    wr(9, 16'd40);
    set_grp(0, 16'h0100);
    wr(0, 16'h0001);
    for (int k = 0; k < 20; k++) begin
      set_grp(0, probe[15:0] + 16'd1);
      step();
      if (k == 0) head = out_data[15:0];
    end
    chk("R11 overflow set", 64'(ovf), 64'd1);
    chk("R11 still capturing", 64'(state), 64'd2);
    chk("R12 head held", 64'(out_data[15:0]), 64'(head));
    wr(10, 16'h0001);
    chk("R11 set beats clear", 64'(ovf), 64'd1);
    wr(0, 16'h0000);
    wr(10, 16'h0001);
    chk("R11 cleared", 64'(ovf), 64'd0);
    out_ready = 1'b1;
    d0 = out_data[15:0];
    t0 = out_data[31:16];
    for (int k = 0; k < DEP; k++) begin
      chk("R12 word valid", 64'(out_valid), 64'd1);
      chk("R12 order", 64'(out_data[15:0]), 64'(d0 + 16'(k)));
      chk("R10 timestamp step", 64'(out_data[31:16]), 64'(t0 + 16'(k)));
      step();
    end
    chk("R11 excess dropped", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule